// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block records the wall-clock time at which a tamper event is seen. On a qualifying event it copies six live BCD time fields (seconds, minutes, hours, day of month, month, year) into a bank of snapshot registers in a single clock. It then raises two event flags that sit in two separate status registers, and it drives an interrupt request while either flag is set and the interrupt is enabled.

A configuration register selects the capture policy. In overwrite mode every event replaces the snapshot. In keep-first mode the first event is held, and no later event changes it until software has cleared both flags. A disable bit blocks capture. A second trigger source, the backup-supply switch-over pulse, can be allowed to capture as well, and it is blocked by default. Software sees the flags, configuration and snapshot through a small byte-wide register port with a combinational read path. The tamper pulse is assumed to be already synchronised and debounced, and the live time comes from an external counter.

Top module: `tamper_ts_capture`

## Requirements
- R1: After reset both flags, the interrupt enable, all configuration bits and all six snapshot fields are 0, and the interrupt request is low.
- R2: A capture stores each live field masked to its width in the cycle after the event: seconds and minutes keep 7 bits, hours and day 6 bits, month 5 bits and year 8 bits. The fields read back at addresses 3 (seconds), 4 (minutes), 5 (hours), 6 (day), 7 (month) and 8 (year).
- R3: A qualifying event sets flag A (address 0, bit 0) and flag B (address 1, bit 0) in the following cycle.
- R4: With the mode bit clear (address 2, bit 1 = 0), every qualifying event overwrites the snapshot with the time present in the event cycle.
- R5: With the mode bit set, an event that arrives while either flag is set leaves the snapshot unchanged but still sets both flags.
- R6: In keep-first mode, clearing only one flag keeps the snapshot frozen. Once both flags are clear, the next event captures again.
- R7: A flag is cleared by writing 0 to its bit. Writing 1 to that bit has no effect and cannot set the flag.
- R8: When a flag clear and a qualifying event land in the same cycle, the flag ends up set. Capture gating uses the flag values held at the start of that cycle.
- R9: With the disable bit set (address 2, bit 0), events neither set flags nor change the snapshot.
- R10: The switch-over input triggers a capture only when its enable (address 2, bit 2) is set. Otherwise it is ignored.
- R11: The interrupt request equals the interrupt enable (address 1, bit 1) ANDed with the OR of the two flags, with no added delay.
- R12: Writes to addresses 3 to 8 do not change the snapshot. Addresses 9 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_evt | input | 1 | Synchronised single-cycle tamper pulse |
| batt_evt | input | 1 | Single-cycle backup-supply switch-over pulse |
| live_sec | input | 8 | Live seconds, BCD |
| live_min | input | 8 | Live minutes, BCD |
| live_hour | input | 8 | Live hours, BCD |
| live_day | input | 8 | Live day of month, BCD |
| live_mon | input | 8 | Live month, BCD |
| live_year | input | 8 | Live year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data |
| ts_sec | output | 8 | Snapshot seconds |
| ts_min | output | 8 | Snapshot minutes |
| ts_hour | output | 8 | Snapshot hours |
| ts_day | output | 8 | Snapshot day of month |
| ts_mon | output | 8 | Snapshot month |
| ts_year | output | 8 | Snapshot year |
| evt_flag_a | output | 1 | Event flag A |
| evt_flag_b | output | 1 | Event flag B |
| irq_req | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. A store copies the masked live time, and a fired trigger leaves both flags set. The snapshot holds still while capture is disabled or frozen, a clear flag never rises without an event, and the interrupt is never raised without a flag. Other behaviours need ordered sequences that only the bench scenarios create. These are the freeze surviving a single-flag clear, capture resuming after both flags clear, the event winning over a same-cycle clear, and the switch-over enable. The bench sweeps every combination of configuration bits and both trigger sources through the same sequence, and it compares each cycle against a reference model that it computes itself.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned BYTE_W     = 8;

  // register addresses
  localparam int unsigned ADR_FLAG_A = 0;
  localparam int unsigned ADR_FLAG_B = 1;
  localparam int unsigned ADR_CFG    = 2;
  localparam int unsigned ADR_SNAP0  = 3;

  // bit positions inside the registers
  localparam int unsigned BIT_FLAG   = 0;
  localparam int unsigned BIT_IE     = 1;
  localparam int unsigned BIT_OFF    = 0;
  localparam int unsigned BIT_KEEP   = 1;
  localparam int unsigned BIT_SW     = 2;

  typedef struct packed {
    logic sw_en;
    logic keep;
    logic off;
  } tsc_cfg_t;

  // low-order mask for a field of the given width
  function automatic logic [BYTE_W-1:0] width_mask(input int unsigned w);
    logic [BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      if (i < int'(w)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // packed mask vector, field 0 in the lowest byte
  function automatic logic [NUM_FIELDS*BYTE_W-1:0] pack_masks(
    input int unsigned w0, input int unsigned w1, input int unsigned w2,
    input int unsigned w3, input int unsigned w4, input int unsigned w5);
    return {width_mask(w5), width_mask(w4), width_mask(w3),
            width_mask(w2), width_mask(w1), width_mask(w0)};
  endfunction
endpackage

// File: rtl/tsc_trigger.sv
module tsc_trigger
  import tsc_pkg::*;
(
  input  logic     tamper_evt,
  input  logic     batt_evt,
  input  tsc_cfg_t cfg,
  input  logic     flag_a,
  input  logic     flag_b,
  output logic     cap_fire,
  output logic     cap_store
);
  logic any_src;
  logic frozen;

  always_comb begin
    any_src   = tamper_evt | (batt_evt & cfg.sw_en);
    cap_fire  = any_src & ~cfg.off;
    frozen    = cfg.keep & (flag_a | flag_b);
    cap_store = cap_fire & ~frozen;
  end
endmodule

// File: rtl/tsc_ctrl_regs.sv
module tsc_ctrl_regs
  import tsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cap_fire,
  output tsc_cfg_t          cfg,
  output logic              flag_a,
  output logic              flag_b,
  output logic              irq_en
);
  logic wr_a, wr_b, wr_c;

  always_comb begin
    wr_a = wr && (addr == ADDR_W'(ADR_FLAG_A));
    wr_b = wr && (addr == ADDR_W'(ADR_FLAG_B));
    wr_c = wr && (addr == ADDR_W'(ADR_CFG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      irq_en <= 1'b0;
      cfg    <= '0;
    end else begin
      // event has priority over a clear written in the same cycle
      if (cap_fire)                        flag_a <= 1'b1;
      else if (wr_a && !wdata[BIT_FLAG])   flag_a <= 1'b0;
      if (cap_fire)                        flag_b <= 1'b1;
      else if (wr_b && !wdata[BIT_FLAG])   flag_b <= 1'b0;
      if (wr_b) irq_en <= wdata[BIT_IE];
      if (wr_c) begin
        cfg.off   <= wdata[BIT_OFF];
        cfg.keep  <= wdata[BIT_KEEP];
        cfg.sw_en <= wdata[BIT_SW];
      end
    end
  end
endmodule

// File: rtl/tsc_snapshot.sv
module tsc_snapshot
  import tsc_pkg::*;
#(
  parameter logic [NUM_FIELDS*BYTE_W-1:0] FIELD_MASKS = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         store,
  input  logic [NUM_FIELDS*BYTE_W-1:0] live_bus,
  output logic [NUM_FIELDS*BYTE_W-1:0] ts_bus
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [BYTE_W-1:0] FMASK = FIELD_MASKS[g*BYTE_W +: BYTE_W];
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (store) q <= live_bus[g*BYTE_W +: BYTE_W] & FMASK;
    end
    assign ts_bus[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/tsc_rdmux.sv
module tsc_rdmux
  import tsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  tsc_cfg_t                     cfg,
  input  logic                         flag_a,
  input  logic                         flag_b,
  input  logic                         irq_en,
  input  logic [NUM_FIELDS*BYTE_W-1:0] ts_bus,
  output logic [BYTE_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_FLAG_A)) begin
      rdata[BIT_FLAG] = flag_a;
    end else if (addr == ADDR_W'(ADR_FLAG_B)) begin
      rdata[BIT_FLAG] = flag_b;
      rdata[BIT_IE]   = irq_en;
    end else if (addr == ADDR_W'(ADR_CFG)) begin
      rdata[BIT_OFF]  = cfg.off;
      rdata[BIT_KEEP] = cfg.keep;
      rdata[BIT_SW]   = cfg.sw_en;
    end else begin
      for (int i = 0; i < int'(NUM_FIELDS); i++) begin
        if (addr == ADDR_W'(ADR_SNAP0 + i)) rdata = ts_bus[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/tamper_ts_capture.sv
module tamper_ts_capture
  import tsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SEC_W  = 7,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAY_W  = 6,
  parameter int unsigned MON_W  = 5,
  parameter int unsigned YEAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper_evt,
  input  logic              batt_evt,
  input  logic [7:0]        live_sec,
  input  logic [7:0]        live_min,
  input  logic [7:0]        live_hour,
  input  logic [7:0]        live_day,
  input  logic [7:0]        live_mon,
  input  logic [7:0]        live_year,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [7:0]        ts_sec,
  output logic [7:0]        ts_min,
  output logic [7:0]        ts_hour,
  output logic [7:0]        ts_day,
  output logic [7:0]        ts_mon,
  output logic [7:0]        ts_year,
  output logic              evt_flag_a,
  output logic              evt_flag_b,
  output logic              irq_req
);
  localparam logic [NUM_FIELDS*BYTE_W-1:0] MASKS =
    pack_masks(SEC_W, MIN_W, HOUR_W, DAY_W, MON_W, YEAR_W);

  tsc_cfg_t                     cfg_q;
  logic                         cap_fire;
  logic                         cap_store;
  logic                         irq_en_q;
  logic [NUM_FIELDS*BYTE_W-1:0] live_bus;
  logic [NUM_FIELDS*BYTE_W-1:0] ts_bus;

  assign live_bus = {live_year, live_mon, live_day, live_hour, live_min, live_sec};

  tsc_trigger u_trig (
    .tamper_evt (tamper_evt),
    .batt_evt   (batt_evt),
    .cfg        (cfg_q),
    .flag_a     (evt_flag_a),
    .flag_b     (evt_flag_b),
    .cap_fire   (cap_fire),
    .cap_store  (cap_store)
  );

  tsc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cap_fire (cap_fire),
    .cfg      (cfg_q),
    .flag_a   (evt_flag_a),
    .flag_b   (evt_flag_b),
    .irq_en   (irq_en_q)
  );

  tsc_snapshot #(.FIELD_MASKS(MASKS)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .store    (cap_store),
    .live_bus (live_bus),
    .ts_bus   (ts_bus)
  );

  tsc_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr   (reg_addr),
    .cfg    (cfg_q),
    .flag_a (evt_flag_a),
    .flag_b (evt_flag_b),
    .irq_en (irq_en_q),
    .ts_bus (ts_bus),
    .rdata  (reg_rdata)
  );

  assign {ts_year, ts_mon, ts_day, ts_hour, ts_min, ts_sec} = ts_bus;
  assign irq_req = irq_en_q & (evt_flag_a | evt_flag_b);
endmodule

// File: rtl/tamper_ts_capture_chk.sv
module tamper_ts_capture_chk
  import tsc_pkg::*;
#(
  parameter logic [NUM_FIELDS*BYTE_W-1:0] MASKS = '1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tamper_evt,
  input logic                         cfg_off,
  input logic                         cfg_keep,
  input logic                         cfg_sw,
  input logic                         cap_fire,
  input logic                         cap_store,
  input logic                         flag_a,
  input logic                         flag_b,
  input logic                         irq,
  input logic [NUM_FIELDS*BYTE_W-1:0] live_bus,
  input logic [NUM_FIELDS*BYTE_W-1:0] ts_bus
);
  p_store_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_store |=> ts_bus == ($past(live_bus) & MASKS));

  p_fire_sets_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (flag_a && flag_b));

  p_frozen_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_keep && (flag_a || flag_b)) |=> $stable(ts_bus));

  p_no_self_set_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !flag_a) |=> !flag_a);

  p_no_self_set_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !flag_b) |=> !flag_b);

  p_off_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off |=> $stable(ts_bus));

  p_sw_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sw && !tamper_evt) |-> !cap_fire);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_a || flag_b));
endmodule

bind tamper_ts_capture tamper_ts_capture_chk #(.MASKS(MASKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tamper_evt (tamper_evt),
  .cfg_off    (cfg_q.off),
  .cfg_keep   (cfg_q.keep),
  .cfg_sw     (cfg_q.sw_en),
  .cap_fire   (cap_fire),
  .cap_store  (cap_store),
  .flag_a     (evt_flag_a),
  .flag_b     (evt_flag_b),
  .irq        (irq_req),
  .live_bus   (live_bus),
  .ts_bus     (ts_bus)
);

// File: tb/tamper_ts_capture_tb_top.sv
module tamper_ts_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tamper_evt = 1'b0, batt_evt = 1'b0;
  logic [7:0] live_sec = 0, live_min = 0, live_hour = 0;
  logic [7:0] live_day = 0, live_mon = 0, live_year = 0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] ts_sec, ts_min, ts_hour, ts_day, ts_mon, ts_year;
  logic evt_flag_a, evt_flag_b, irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_ts [6];
  logic m_fa, m_fb, m_ie, m_off, m_keep, m_sw;
  localparam logic [7:0] FMASK [6] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'hFF};

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_ts_capture dut_i (
    .clk(clk), .rst_n(rst_n), .tamper_evt(tamper_evt), .batt_evt(batt_evt),
    .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
    .live_day(live_day), .live_mon(live_mon), .live_year(live_year),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ts_sec(ts_sec), .ts_min(ts_min), .ts_hour(ts_hour),
    .ts_day(ts_day), .ts_mon(ts_mon), .ts_year(ts_year),
    .evt_flag_a(evt_flag_a), .evt_flag_b(evt_flag_b), .irq_req(irq_req)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // garbage placed above each field width to exercise masking
  task automatic set_live(input int k);
    live_sec  = to_bcd((k * 13) % 60) | 8'h80;
    live_min  = to_bcd((k * 29) % 60) | 8'h80;
    live_hour = to_bcd(k % 24) | 8'hC0;
    live_day  = to_bcd(k % 28 + 1) | 8'hC0;
    live_mon  = to_bcd(k % 12 + 1) | 8'hE0;
    live_year = to_bcd((k * 7) % 100);
  endtask

  function automatic logic [7:0] model_read(input int a);
    case (a)
      0: return {7'd0, m_fa};
      1: return {6'd0, m_ie, m_fb};
      2: return {5'd0, m_sw, m_keep, m_off};
      3, 4, 5, 6, 7, 8: return m_ts[a-3];
      default: return 8'd0;
    endcase
  endfunction

  task automatic check_all(input string tag);
    check({tag, " ts_sec"},  ts_sec,  m_ts[0]);
    check({tag, " ts_min"},  ts_min,  m_ts[1]);
    check({tag, " ts_hour"}, ts_hour, m_ts[2]);
    check({tag, " ts_day"},  ts_day,  m_ts[3]);
    check({tag, " ts_mon"},  ts_mon,  m_ts[4]);
    check({tag, " ts_year"}, ts_year, m_ts[5]);
    check({tag, " flag_a"},  {7'd0, evt_flag_a}, {7'd0, m_fa});
    check({tag, " flag_b"},  {7'd0, evt_flag_b}, {7'd0, m_fb});
    check("R11 irq", {7'd0, irq_req}, {7'd0, m_ie & (m_fa | m_fb)});
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #1;
      check((a > 8) ? "R12 unmapped read" : {tag, " readback"}, reg_rdata, model_read(a));
    end
    reg_addr = 4'd0;
  endtask

  // one cycle of stimulus; called at a falling edge
  task automatic step(input string tag, input logic t, input logic b,
                      input logic w, input int a, input logic [7:0] d);
    logic cap, frozen;
    tamper_evt = t; batt_evt = b;
    reg_wr = w; reg_addr = 4'(a); reg_wdata = d;
    cap    = (t | (b & m_sw)) & ~m_off;
    frozen = m_keep & (m_fa | m_fb);
    @(posedge clk);
    #1;
    if (cap && !frozen) begin
      m_ts[0] = live_sec & FMASK[0];  m_ts[1] = live_min & FMASK[1];
      m_ts[2] = live_hour & FMASK[2]; m_ts[3] = live_day & FMASK[3];
      m_ts[4] = live_mon & FMASK[4];  m_ts[5] = live_year & FMASK[5];
    end
    if (w) begin
      if (a == 0 && !d[0]) m_fa = 1'b0;
      if (a == 1) begin
        if (!d[0]) m_fb = 1'b0;
        m_ie = d[1];
      end
      if (a == 2) begin
        m_off = d[0]; m_keep = d[1]; m_sw = d[2];
      end
    end
    if (cap) begin m_fa = 1'b1; m_fb = 1'b1; end
    tamper_evt = 1'b0; batt_evt = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_ts[i] = 8'd0;
    m_fa = 0; m_fb = 0; m_ie = 0; m_off = 0; m_keep = 0; m_sw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R12: writes into the snapshot range are ignored
    set_live(5);
    step("R2 first capture", 1, 0, 0, 0, 0);
    for (int a = 3; a <= 8; a++) step("R12 snapshot write", 0, 0, 1, a, 8'h55);
    // R7: writing 1 keeps a flag, writing 0 clears it, 1 cannot set it again
    step("R7 write one", 0, 0, 1, 0, 8'h01);
    step("R7 clear a", 0, 0, 1, 0, 8'h00);
    step("R7 write one no set", 0, 0, 1, 0, 8'hFF);
    step("R11 enable irq", 0, 0, 1, 1, 8'h03);
    step("R7 clear b", 0, 0, 1, 1, 8'h02);

    // sweep of configuration x trigger source
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int src = 0; src < 2; src++) begin
        int base;
        base = cfg * 10 + src * 5 + 1;
        step("R9 R10 set config", 0, 0, 1, 2, 8'(cfg));
        step("R7 clear a", 0, 0, 1, 0, 8'h00);
        step("R7 clear b", 0, 0, 1, 1, {6'd0, 1'(cfg % 2), 1'b0});
        set_live(base);
        step("R3 R9 R10 event one", src == 0, src == 1, 0, 0, 0);
        set_live(base + 1);
        step("R4 R5 event two", src == 0, src == 1, 0, 0, 0);
        step("R6 clear only a", 0, 0, 1, 0, 8'h00);
        set_live(base + 2);
        step("R6 event after partial clear", src == 0, src == 1, 0, 0, 0);
        set_live(base + 3);
        step("R8 clear with event", src == 0, src == 1, 1, 0, 8'h00);
        step("R6 clear a", 0, 0, 1, 0, 8'h00);
        step("R6 clear b", 0, 0, 1, 1, 8'h02);
        set_live(base + 4);
        step("R6 event after full clear", src == 0, src == 1, 0, 0, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule